// File: doc/BRIEF.md
# Rename Stall Controller

This block sequences one thread through the rename stage of an out-of-order pipeline. Each cycle it looks at how many instructions decode presents, how much room the reorder buffer, issue queue and load/store queue still have, stall requests from execute and from commit, squash requests, and serializing marks on incoming instructions. From these it decides how many instructions may be renamed this cycle, which thread state comes next, when to hold and when to release decode, and how many instructions move into or out of a skid buffer. Only the bookkeeping of the skid buffer lives here; instruction payloads and register mapping are handled elsewhere.

Free-entry counts are reduced by an in-flight count: instructions already granted whose arrival the back end has not yet reported. When a full structure cuts a group short, the stage records which structure was responsible and bumps a per-structure event counter. A serializing instruction parks the thread until the reorder buffer is empty and nothing is in flight, then renames alone. A squash wins over every other condition.

Top module: `rn_stall_ctrl`

## Requirements
- R1: After reset the thread state is Idle (code 1), the skid count, in-flight count and all three event counters are zero.
- R2: In Running (0), Idle (1) or Unblocking (5) with no stall, squash or serializing arrival, the grant equals the minimum of WIDTH, the pending count (skid plus arrivals), and the smallest free count after subtracting the in-flight count (floored at zero).
- R3: When a group is cut short because the capacity is below min(pending, WIDTH), the thread enters Blocked, the full source is reported with priority reorder buffer (0), then issue queue (1), then load/store queue (2), picking the first whose reduced free count is below min(pending, WIDTH), and that source's event counter increments; otherwise the source output is 3.
- R4: A stall request from execute or from commit blocks the stage: no grant, all arrivals go to the skid buffer, the state becomes Blocked (4) and the hold pulse to decode is high in that cycle.
- R5: Unblocking drains the skid buffer before new arrivals; the state returns to Running and the release pulse to decode is high only in the cycle the pending count is fully granted. Skid push and pop counts match the instructions entering and leaving the skid buffer.
- R6: An arrival marked serializing (or following a serialize-after mark) sends the thread to SerializeStall (6) with its whole group in the skid buffer; it is renamed alone (grant 1) only in a cycle with no stall, the empty flag of the reorder buffer high, zero in-flight count and nonzero capacity.
- R7: A serialize-after mark makes the next arriving instruction, also in a later cycle, serializing.
- R8: A squash request in any state clears the skid buffer, the in-flight count and any pending serialize mark, and gives no grant; the thread passes StartSquash (2), then Squashing (3) for one cycle, then Idle, discarding arrivals meanwhile.
- R9: The in-flight count rises by the grant and falls by the absorbed count reported by the back end each cycle.
- R10: Blocked is left for Unblocking only in a cycle with no stall request and a capacity of at least min(pending, WIDTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_cnt | input | GW | Instructions presented by decode this cycle |
| dec_ser_before | input | 1 | First arriving instruction is serializing |
| dec_ser_after | input | 1 | Arriving group ends with a serialize-after instruction |
| rob_free | input | FREE_W | Free reorder buffer entries |
| iq_free | input | FREE_W | Free issue queue entries |
| lsq_free | input | FREE_W | Free load/store queue entries |
| rob_empty | input | 1 | Reorder buffer is empty |
| absorbed_cnt | input | GW | Instructions the back end counted this cycle |
| iew_stall | input | 1 | Stall request from execute |
| commit_stall | input | 1 | Stall request from commit |
| squash | input | 1 | Squash request |
| thread_state | output | 3 | Current thread state code |
| grant_cnt | output | GW | Instructions renamed this cycle |
| dec_hold | output | 1 | Hold pulse to decode |
| dec_release | output | 1 | Release pulse to decode |
| skid_push_cnt | output | GW | Arrivals written to the skid buffer |
| skid_pop_cnt | output | GW | Skid entries renamed this cycle |
| skid_count | output | KW | Skid buffer occupancy |
| inflight_cnt | output | FREE_W | Granted instructions not yet absorbed |
| full_src | output | 2 | Full-stall source this cycle |
| rob_full_events | output | EVW | Reorder-buffer full events |
| iq_full_events | output | EVW | Issue-queue full events |
| lsq_full_events | output | EVW | Load/store-queue full events |

## Verification
Every cycle the assertions check that a grant never exceeds any structure's room once the in-flight count is added, that stalls and squash states grant nothing, that a serialize stall grants nothing while the back end is busy, and that the hold, release and squash sequences land in the right next state. The exact grant size, the priority between simultaneously full structures, the carry-over of a serialize-after mark across idle cycles, and the skid push/pop split only show up through the bench's scenarios compared against its own model of the thread.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_IDLE      = 3'd1,
    ST_SQ_START  = 3'd2,
    ST_SQ        = 3'd3,
    ST_BLOCKED   = 3'd4,
    ST_UNBLOCK   = 3'd5,
    ST_SER_STALL = 3'd6
  } thr_state_e;

  typedef enum logic [1:0] {
    SRC_ROB  = 2'd0,
    SRC_IQ   = 2'd1,
    SRC_LSQ  = 2'd2,
    SRC_NONE = 2'd3
  } full_src_e;
endpackage

// File: rtl/rn_capacity.sv
module rn_capacity
  import rn_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int FREE_W = 6,
  parameter int NW     = 6,
  localparam int GW    = $clog2(WIDTH + 1),
  localparam int CW    = ((FREE_W > NW) ? FREE_W : NW) + 1
) (
  input  logic [FREE_W-1:0] rob_free,
  input  logic [FREE_W-1:0] iq_free,
  input  logic [FREE_W-1:0] lsq_free,
  input  logic [FREE_W-1:0] inflight,
  input  logic [NW-1:0]     pending,
  output logic [GW-1:0]     cap,
  output logic              limited,
  output full_src_e         src
);
  logic [FREE_W-1:0] free_a [3];
  logic [CW-1:0]     eff    [3];
  logic [CW-1:0]     min_eff;
  logic [CW-1:0]     want;

  assign free_a[0] = rob_free;
  assign free_a[1] = iq_free;
  assign free_a[2] = lsq_free;

  // room left per structure once in-flight instructions are accounted for
  genvar gi;
  generate
    for (gi = 0; gi < 3; gi++) begin : g_eff
      assign eff[gi] = (free_a[gi] > inflight) ? CW'(free_a[gi] - inflight) : '0;
    end
  endgenerate

  always_comb begin
    min_eff = eff[0];
    for (int i = 1; i < 3; i++) begin
      if (eff[i] < min_eff) min_eff = eff[i];
    end
    want    = (CW'(pending) < CW'(WIDTH)) ? CW'(pending) : CW'(WIDTH);
    cap     = (min_eff < CW'(WIDTH)) ? GW'(min_eff) : GW'(WIDTH);
    limited = (min_eff < want);
    // lowest index wins: reorder buffer, then issue queue, then load/store (R3)
    src = SRC_NONE;
    for (int i = 2; i >= 0; i--) begin
      if (eff[i] < want) src = full_src_e'(2'(i));
    end
  end
endmodule

// File: rtl/rn_inflight.sv
module rn_inflight #(
  parameter int FREE_W = 6,
  parameter int GW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [GW-1:0]     grant,
  input  logic [GW-1:0]     absorbed,
  output logic [FREE_W-1:0] count
);
  logic [FREE_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = clr || (grant != '0) || (absorbed != '0);
    cnt_d  = clr ? '0 : (cnt_q + FREE_W'(grant) - FREE_W'(absorbed));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // back end can never report more than was sent (R9)
  p_absorb_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    FREE_W'(absorbed) <= cnt_q);
  // a clear empties the count on the next cycle (R8)
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/rn_full_events.sv
module rn_full_events
  import rn_pkg::*;
#(
  parameter int EVW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  full_src_e      src,
  output logic [EVW-1:0] rob_ev,
  output logic [EVW-1:0] iq_ev,
  output logic [EVW-1:0] lsq_ev
);
  genvar gi;
  generate
    for (gi = 0; gi < 3; gi++) begin : g_ctr
      logic [EVW-1:0] cnt_q;
      logic           hit;
      assign hit = fire && (src == full_src_e'(2'(gi)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (hit) cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  assign rob_ev = g_ctr[0].cnt_q;
  assign iq_ev  = g_ctr[1].cnt_q;
  assign lsq_ev = g_ctr[2].cnt_q;

  // a recorded full stall always names a structure (R3)
  p_fire_named_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (src != SRC_NONE));
endmodule

// File: rtl/rn_stall_ctrl.sv
module rn_stall_ctrl
  import rn_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int FREE_W     = 6,
  parameter int SKID_DEPTH = 16,
  parameter int EVW        = 8,
  localparam int GW        = $clog2(WIDTH + 1),
  localparam int KW        = $clog2(SKID_DEPTH + 1),
  localparam int NW        = KW + 1,
  localparam int XW        = FREE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GW-1:0]     dec_cnt,
  input  logic              dec_ser_before,
  input  logic              dec_ser_after,
  input  logic [FREE_W-1:0] rob_free,
  input  logic [FREE_W-1:0] iq_free,
  input  logic [FREE_W-1:0] lsq_free,
  input  logic              rob_empty,
  input  logic [GW-1:0]     absorbed_cnt,
  input  logic              iew_stall,
  input  logic              commit_stall,
  input  logic              squash,
  output logic [2:0]        thread_state,
  output logic [GW-1:0]     grant_cnt,
  output logic              dec_hold,
  output logic              dec_release,
  output logic [GW-1:0]     skid_push_cnt,
  output logic [GW-1:0]     skid_pop_cnt,
  output logic [KW-1:0]     skid_count,
  output logic [FREE_W-1:0] inflight_cnt,
  output logic [1:0]        full_src,
  output logic [EVW-1:0]    rob_full_events,
  output logic [EVW-1:0]    iq_full_events,
  output logic [EVW-1:0]    lsq_full_events
);
  thr_state_e        st_q, st_d;
  logic [KW-1:0]     skid_q, skid_d;
  logic              ser_pend_q, ser_pend_d;
  logic [NW-1:0]     pend, left;
  logic [GW-1:0]     cap, gr, pop, push;
  logic              limited, stall, ser_hit, arrivals, fire;
  full_src_e         cap_src;

  assign pend     = NW'(skid_q) + NW'(dec_cnt);
  assign stall    = iew_stall || commit_stall;
  assign arrivals = (dec_cnt != '0);
  assign ser_hit  = arrivals && (dec_ser_before || ser_pend_q);

  rn_capacity #(.WIDTH(WIDTH), .FREE_W(FREE_W), .NW(NW)) i_cap (
    .rob_free (rob_free),
    .iq_free  (iq_free),
    .lsq_free (lsq_free),
    .inflight (inflight_cnt),
    .pending  (pend),
    .cap      (cap),
    .limited  (limited),
    .src      (cap_src)
  );

  rn_inflight #(.FREE_W(FREE_W), .GW(GW)) i_infl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (squash),
    .grant    (gr),
    .absorbed (absorbed_cnt),
    .count    (inflight_cnt)
  );

  rn_full_events #(.EVW(EVW)) i_ev (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .src    (cap_src),
    .rob_ev (rob_full_events),
    .iq_ev  (iq_full_events),
    .lsq_ev (lsq_full_events)
  );

  // next-state process
  always_comb begin
    st_d       = st_q;
    skid_d     = skid_q;
    ser_pend_d = ser_pend_q;
    gr         = '0;
    pop        = '0;
    push       = '0;
    left       = '0;
    dec_hold   = 1'b0;
    dec_release = 1'b0;
    fire       = 1'b0;
    if (squash) begin
      st_d       = ST_SQ_START;
      skid_d     = '0;
      ser_pend_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_SQ_START: st_d = ST_SQ;
        ST_SQ:       st_d = ST_IDLE;
        ST_RUN, ST_IDLE, ST_UNBLOCK: begin
          if (ser_hit) begin
            st_d       = ST_SER_STALL;
            skid_d     = KW'(pend);
            push       = dec_cnt;
            ser_pend_d = dec_ser_after;
          end else if (stall) begin
            st_d       = ST_BLOCKED;
            dec_hold   = 1'b1;
            skid_d     = KW'(pend);
            push       = dec_cnt;
            ser_pend_d = ser_pend_q || (arrivals && dec_ser_after);
          end else begin
            gr         = (NW'(cap) < pend) ? cap : GW'(pend);
            left       = pend - NW'(gr);
            pop        = (NW'(skid_q) < NW'(gr)) ? GW'(skid_q) : gr;
            push       = dec_cnt - (gr - pop);
            skid_d     = KW'(left);
            ser_pend_d = ser_pend_q || (arrivals && dec_ser_after);
            if (left == '0) begin
              st_d        = ((st_q == ST_UNBLOCK) || (pend != '0)) ? ST_RUN : ST_IDLE;
              dec_release = (st_q == ST_UNBLOCK);
            end else if (limited) begin
              st_d     = ST_BLOCKED;
              dec_hold = 1'b1;
              fire     = 1'b1;
            end else begin
              st_d = ST_UNBLOCK;
            end
          end
        end
        ST_BLOCKED: begin
          push       = dec_cnt;
          skid_d     = KW'(pend);
          ser_pend_d = ser_pend_q || (arrivals && (dec_ser_before || dec_ser_after));
          if (!stall && !limited) st_d = ST_UNBLOCK;
        end
        ST_SER_STALL: begin
          push       = dec_cnt;
          ser_pend_d = ser_pend_q || (arrivals && (dec_ser_before || dec_ser_after));
          if (!stall && rob_empty && (inflight_cnt == '0) && (cap != '0)) begin
            gr     = GW'(1);
            pop    = GW'(1);
            skid_d = KW'(pend - NW'(1));
            st_d   = (pend > NW'(1)) ? ST_UNBLOCK : ST_RUN;
          end else begin
            skid_d = KW'(pend);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      skid_q     <= '0;
      ser_pend_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      skid_q     <= skid_d;
      ser_pend_q <= ser_pend_d;
    end
  end

  assign thread_state  = st_q;
  assign grant_cnt     = gr;
  assign skid_push_cnt = push;
  assign skid_pop_cnt  = pop;
  assign skid_count    = skid_q;
  assign full_src      = fire ? cap_src : SRC_NONE;

  // a grant never overruns a structure once in-flight work is counted (R2)
  p_grant_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_cnt != '0) |-> ((XW'(rob_free) >= XW'(inflight_cnt) + XW'(grant_cnt)) &&
                           (XW'(iq_free)  >= XW'(inflight_cnt) + XW'(grant_cnt)) &&
                           (XW'(lsq_free) >= XW'(inflight_cnt) + XW'(grant_cnt))));
  p_grant_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_cnt <= GW'(WIDTH));
  // stall requests from either later stage stop renaming (R4)
  p_stall_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iew_stall || commit_stall) |-> (grant_cnt == '0));
  p_hold_enters_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hold |=> (thread_state == 3'(ST_BLOCKED)));
  // release pulse coincides with the return to Running (R5)
  p_release_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_release |=> (thread_state == 3'(ST_RUN)));
  p_skid_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    skid_count <= KW'(SKID_DEPTH));
  // serialize stall holds while the back end is busy (R6)
  p_ser_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((thread_state == 3'(ST_SER_STALL)) && !(rob_empty && (inflight_cnt == '0)))
      |-> (grant_cnt == '0));
  // squash sequence (R8)
  p_squash_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (thread_state == 3'(ST_SQ_START)));
  p_start_then_sq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((thread_state == 3'(ST_SQ_START)) && !squash) |=> (thread_state == 3'(ST_SQ)));
  p_squash_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((thread_state == 3'(ST_SQ_START)) || (thread_state == 3'(ST_SQ)))
      |-> ((grant_cnt == '0) && (skid_count == '0)));
endmodule

// File: tb/test_rn_stall_ctrl.sv
module test_rn_stall_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 4;
  localparam int DEPTH = 16;
  localparam int GW    = 3;
  localparam int KW    = 5;
  localparam int FW    = 6;
  localparam int EVW   = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [GW-1:0] dec_cnt;
  logic          dec_ser_before, dec_ser_after;
  logic [FW-1:0] rob_free, iq_free, lsq_free;
  logic          rob_empty;
  logic [GW-1:0] absorbed_cnt;
  logic          iew_stall, commit_stall, squash;
  logic [2:0]    thread_state;
  logic [GW-1:0] grant_cnt, skid_push_cnt, skid_pop_cnt;
  logic          dec_hold, dec_release;
  logic [KW-1:0] skid_count;
  logic [FW-1:0] inflight_cnt;
  logic [1:0]    full_src;
  logic [EVW-1:0] rob_full_events, iq_full_events, lsq_full_events;

  int checks = 0;
  int errors = 0;

  // bench model of the thread
  int m_st, m_k, m_f, m_p;
  int m_ev [3];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rn_stall_ctrl #(.WIDTH(W), .FREE_W(FW), .SKID_DEPTH(DEPTH), .EVW(EVW)) i_rn_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .dec_cnt(dec_cnt), .dec_ser_before(dec_ser_before),
    .dec_ser_after(dec_ser_after), .rob_free(rob_free), .iq_free(iq_free),
    .lsq_free(lsq_free), .rob_empty(rob_empty), .absorbed_cnt(absorbed_cnt),
    .iew_stall(iew_stall), .commit_stall(commit_stall), .squash(squash),
    .thread_state(thread_state), .grant_cnt(grant_cnt), .dec_hold(dec_hold),
    .dec_release(dec_release), .skid_push_cnt(skid_push_cnt),
    .skid_pop_cnt(skid_pop_cnt), .skid_count(skid_count), .inflight_cnt(inflight_cnt),
    .full_src(full_src), .rob_full_events(rob_full_events),
    .iq_full_events(iq_full_events), .lsq_full_events(lsq_full_events)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int room(input int free, input int infl);
    return (free > infl) ? free - infl : 0;
  endfunction

  // one cycle: drive at the falling edge, check combinational results,
  // let the rising edge pass, check registered results at the next falling edge
  task automatic step(input int d, input bit sb, input bit sa, input int rf, input int iqf,
                      input int lf, input bit re, input int ab, input bit is, input bit cs,
                      input bit sq);
    int e0, e1, e2, me, cap, pend, want, lim, src;
    int g, left, pop, push, blk, rel, fire, nst, nk, np, nf;
    bit stall;
    string tag;
    dec_cnt = GW'(d); dec_ser_before = sb; dec_ser_after = sa;
    rob_free = FW'(rf); iq_free = FW'(iqf); lsq_free = FW'(lf);
    rob_empty = re; absorbed_cnt = GW'(ab);
    iew_stall = is; commit_stall = cs; squash = sq;
    #1;
    e0 = room(rf, m_f); e1 = room(iqf, m_f); e2 = room(lf, m_f);
    me = imin(e0, imin(e1, e2));
    cap = imin(me, W);
    pend = m_k + d;
    want = imin(pend, W);
    lim = (me < want);
    src = (e0 < want) ? 0 : (e1 < want) ? 1 : (e2 < want) ? 2 : 3;
    stall = is || cs;
    g = 0; pop = 0; push = 0; blk = 0; rel = 0; fire = 0;
    nst = m_st; nk = m_k; np = m_p;
    if (sq) begin
      nst = 2; nk = 0; np = 0;
    end else begin
      case (m_st)
        2: nst = 3;
        3: nst = 1;
        0, 1, 5: begin
          if (d != 0 && (sb || m_p != 0)) begin
            nst = 6; nk = pend; push = d; np = sa;
          end else if (stall) begin
            nst = 4; blk = 1; nk = pend; push = d; np = m_p | int'(d != 0 && sa);
          end else begin
            g = imin(pend, cap); left = pend - g; pop = imin(m_k, g);
            push = d - (g - pop); nk = left; np = m_p | int'(d != 0 && sa);
            if (left == 0) begin
              nst = (m_st == 5 || pend != 0) ? 0 : 1;
              rel = (m_st == 5);
            end else if (lim) begin
              nst = 4; blk = 1; fire = 1;
            end else nst = 5;
          end
        end
        4: begin
          push = d; nk = pend; np = m_p | int'(d != 0 && (sb || sa));
          if (!stall && !lim) nst = 5;
        end
        6: begin
          push = d; np = m_p | int'(d != 0 && (sb || sa));
          if (!stall && re && m_f == 0 && cap != 0) begin
            g = 1; pop = 1; nk = pend - 1; nst = (nk != 0) ? 5 : 0;
          end else nk = pend;
        end
        default: nst = 1;
      endcase
    end
    nf = sq ? 0 : m_f + g - ab;
    chk(int'(grant_cnt) == g, (m_st == 6) ? "R6 grant" : "R2 grant", int'(grant_cnt), g);
    chk(int'(full_src) == (fire ? src : 3), "R3 source", int'(full_src), fire ? src : 3);
    chk(int'(dec_hold) == blk, "R4 hold", int'(dec_hold), blk);
    chk(int'(dec_release) == rel, "R5 release", int'(dec_release), rel);
    chk(int'(skid_push_cnt) == push, "R5 push", int'(skid_push_cnt), push);
    chk(int'(skid_pop_cnt) == pop, "R5 pop", int'(skid_pop_cnt), pop);
    @(posedge clk);
    m_st = nst; m_k = nk; m_p = np; m_f = nf;
    if (fire) m_ev[src] = (m_ev[src] + 1) % 256;
    tag = (m_st == 6) ? "R6 state" : (m_st == 2 || m_st == 3) ? "R8 state" :
          (m_st == 4) ? "R4 state" : (m_st == 5) ? "R10 state" : "R5 state";
    @(negedge clk);
    chk(int'(thread_state) == m_st, tag, int'(thread_state), m_st);
    chk(int'(skid_count) == m_k, "R5 skid", int'(skid_count), m_k);
    chk(int'(inflight_cnt) == m_f, "R9 inflight", int'(inflight_cnt), m_f);
    chk(int'(rob_full_events) == m_ev[0], "R3 rob events", int'(rob_full_events), m_ev[0]);
    chk(int'(iq_full_events) == m_ev[1], "R3 iq events", int'(iq_full_events), m_ev[1]);
    chk(int'(lsq_full_events) == m_ev[2], "R3 lsq events", int'(lsq_full_events), m_ev[2]);
  endtask

  // plain cycle with roomy structures and no stall
  task automatic easy(input int d, input bit sb, input bit sa, input bit re, input int ab);
    step(d, sb, sa, 40, 40, 40, re, ab, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic flush();
    step(0, 0, 0, 40, 40, 40, 1, 0, 0, 0, 1);
    easy(0, 0, 0, 1, 0);
    easy(0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_st = 1; m_k = 0; m_f = 0; m_p = 0;
    m_ev[0] = 0; m_ev[1] = 0; m_ev[2] = 0;
    rst_n = 1'b0;
    dec_cnt = '0; dec_ser_before = 0; dec_ser_after = 0;
    rob_free = '0; iq_free = '0; lsq_free = '0; rob_empty = 0;
    absorbed_cnt = '0; iew_stall = 0; commit_stall = 0; squash = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(thread_state == 3'd1, "R1 state", int'(thread_state), 1);
    chk(skid_count == '0, "R1 skid", int'(skid_count), 0);
    chk(inflight_cnt == '0, "R1 inflight", int'(inflight_cnt), 0);
    chk(rob_full_events == '0 && iq_full_events == '0 && lsq_full_events == '0,
        "R1 events", int'(rob_full_events) + int'(iq_full_events) + int'(lsq_full_events), 0);
    @(negedge clk);

    // R2 plain group
    easy(3, 0, 0, 1, 0);
    // R3 reorder buffer short: room 2 of 4 wanted, issue queue roomy
    step(4, 0, 0, 5, 40, 40, 1, 0, 0, 0, 0);
    // R10 leave Blocked once room returns, back end absorbs all five
    step(0, 0, 0, 40, 40, 40, 1, 5, 0, 0, 0);
    // R5 drain skid, release pulse
    easy(0, 0, 0, 1, 0);
    // R3 priority: issue queue (room 1) reported ahead of load/store queue (room 0)
    step(4, 0, 0, 40, 3, 2, 1, 0, 0, 0, 0);
    // R8 squash sequence
    flush();
    // R6 serializing arrival waits for empty back end
    easy(2, 1, 0, 0, 0);
    easy(0, 0, 0, 0, 0);
    easy(0, 0, 0, 1, 0);
    easy(0, 0, 0, 1, 0);
    flush();
    // R7 serialize-after carried to a later arrival
    easy(2, 0, 1, 0, 0);
    easy(0, 0, 0, 0, 2);
    easy(1, 0, 0, 0, 0);
    chk(thread_state == 3'd6, "R7 later arrival serializes", int'(thread_state), 6);
    flush();
    // R4 stall from execute, then from commit
    step(3, 0, 0, 40, 40, 40, 1, 0, 1, 0, 0);
    step(0, 0, 0, 40, 40, 40, 1, 0, 0, 1, 0);
    easy(0, 0, 0, 1, 0);
    easy(0, 0, 0, 1, 0);
    flush();

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int d, rf, iqf, lf, ab, mx;
      bit sb, sa, re, is, cs, sq;
      d = 0;
      if (m_st != 4 && m_st != 6 && m_k <= 8) d = int'($urandom % (W + 1));
      else if (m_k <= 8 && ($urandom % 4) == 0) d = int'($urandom % (W + 1));
      sb = (($urandom % 10) == 0);
      sa = (($urandom % 10) == 0);
      rf  = int'($urandom % 24);
      iqf = int'($urandom % 24);
      lf  = int'($urandom % 24);
      if (($urandom % 3) == 0) rf = 63;
      re = (($urandom % 3) != 0);
      mx = imin(m_f, W);
      ab = int'($urandom % (mx + 1));
      is = (($urandom % 9) == 0);
      cs = (($urandom % 9) == 0);
      sq = (($urandom % 60) == 0);
      step(d, sb, sa, rf, iqf, lf, re, ab, is, cs, sq);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule